// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the target side of a serial flash's erase path. It samples a serial peripheral frame in either clock polarity (mode 0 or mode 3), captures an opcode and up to three address bytes, and waits for chip select to be released before it decides anything. It starts an erase only when every condition holds: the frame ended on a whole byte, the address arrived complete, the write-enable latch was set by an earlier frame, and the region to be erased touches no locked sector. Any erase attempt that fails clears the latch.

The erase itself is modelled by a self-timed cycle counter in place of a memory array. Each erase size has its own duration parameter. The region being erased is shown on `erase_scope` and `erase_base`. A status byte, streamed out on `spi_miso` after a status-read opcode, reports busy, the latch and an erase-error flag. A test input, `fail_inject`, makes the current erase finish with the error flag set.

Top module: `sfe_erase_ctrl`

## Requirements
- R1: In both mode 0 (clock idle low) and mode 3 (clock idle high), MOSI is sampled on each rising `spi_sck` edge, most significant bit first.
- R2: Opcodes 20h, 52h and D8h, each followed by three address bytes, erase a 4-Kbyte, 32-Kbyte or 64-Kbyte block. `erase_scope` then reads 0, 1 or 2. `erase_base` is the address with its low 12, 15 or 16 bits cleared; only the low 18 address bits are kept.
- R3: An erase starts only on the release (rise) of `spi_csn`, and only if the write-enable latch was set by opcode 06h in an earlier frame. An erase opcode sent while the latch is clear does nothing and leaves the latch clear.
- R4: If a frame ends after a bit count that is not a multiple of eight, or before all three address bytes of a block erase have arrived, no erase starts and the latch is cleared.
- R5: Address bits 17:16 select one of four sectors, and `sector_lock[s]` locks sector s. A block erase that falls in a locked sector is refused and the latch is cleared. Locks on other sectors do not block it.
- R6: Opcodes 60h and C7h both start a chip erase. It needs no address, ignores any trailing bytes, and sets `erase_scope` to 3 and `erase_base` to 0. It is refused, with the latch cleared, if any lock bit is set.
- R7: An accepted erase keeps `erase_busy` high for exactly the duration parameter of its size. The latch is cleared when the erase starts, so it reads 0 for the whole erase.
- R8: Opcode 05h streams the status byte on `spi_miso`, most significant bit first, with bits changing on falling `spi_sck` edges. The byte has busy in bit 0, the latch in bit 1 and the error flag in bit 5; all other bits are 0. The byte repeats for as long as the clock runs.
- R9: While an erase is running, every opcode except 05h is ignored. The latch does not change, no new erase starts, and `erase_scope`/`erase_base` keep their values.
- R10: The error flag is set at the end of an erase if `fail_inject` was high in any cycle of that erase. It is cleared when the next erase starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select; its rise ends a frame |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host (status byte) |
| sector_lock | input | SECTORS | Per-sector erase lock, one bit per sector |
| fail_inject | input | 1 | Forces the error flag at the end of the current erase |
| erase_busy | output | 1 | High while the self-timed erase runs |
| erase_scope | output | 2 | Size of the last started erase: 0=4K, 1=32K, 2=64K, 3=chip |
| erase_base | output | ADDR_W | First address of the region of the last started erase |

## Verification
The hardest case to reach from the ports is a command arriving while an erase is running. For that to happen, a complete status read and further command frames must fit inside one erase. The bench shortens the small-block durations so that the table of cases finishes quickly, and lengthens the 64-Kbyte and chip durations so that a two-byte status read, a write-enable frame and a chip-erase frame all land during a single erase. The bench then checks after the erase that none of those frames had any effect. The error flag is reached the same way: `fail_inject` is pulsed mid-erase, and the flag is then watched as it survives a write-enable and is cleared by the next accepted erase.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

   typedef enum logic [1:0] {
      SC_4K   = 2'd0,
      SC_32K  = 2'd1,
      SC_64K  = 2'd2,
      SC_CHIP = 2'd3
   } scope_e;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_E4K   = 8'h20;
   localparam logic [7:0] OP_E32K  = 8'h52;
   localparam logic [7:0] OP_E64K  = 8'hD8;
   localparam logic [7:0] OP_CHIPA = 8'h60;
   localparam logic [7:0] OP_CHIPB = 8'hC7;

   localparam int ST_BUSY = 0;
   localparam int ST_WEL  = 1;
   localparam int ST_ERR  = 5;

   // opcode byte plus three address bytes
   localparam logic [2:0] FRAME_FULL = 3'd4;

   localparam int LOW_4K  = 12;
   localparam int LOW_32K = 15;
   localparam int LOW_64K = 16;

endpackage

// File: rtl/sfe_spi_front.sv
module sfe_spi_front
   import sfe_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              csn,
   input  logic              mosi,
   input  logic [7:0]        status_byte,
   output logic              miso,
   output logic              frame_end,
   output logic              frame_aligned,
   output logic [2:0]        frame_bytes,
   output logic [7:0]        frame_op,
   output logic [ADDR_W-1:0] frame_addr
);

   if (ADDR_W < 8 || ADDR_W > 24) begin : g_bad_addr
      $error("sfe_spi_front: ADDR_W must lie in 8..24");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("sfe_spi_front: SYNC_STAGES must lie in 0..4");
   end

   // bit order: {sck, csn, mosi}
   localparam logic [2:0] IDLE_VEC = 3'b010;

   logic [2:0] raw_vec, syn_vec;
   assign raw_vec = {sck, csn, mosi};

   if (SYNC_STAGES == 0) begin : g_nosync
      assign syn_vec = raw_vec;
   end else begin : g_sync
      logic [2:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= IDLE_VEC;
         end else begin
            chain[0] <= raw_vec;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign syn_vec = chain[SYNC_STAGES-1];
   end

   logic sck_s, csn_s, mosi_s;
   assign {sck_s, csn_s, mosi_s} = syn_vec;

   logic sck_q, csn_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         csn_q <= 1'b1;
      end else begin
         sck_q <= sck_s;
         csn_q <= csn_s;
      end
   end

   logic sck_rise, sck_fall;
   assign sck_rise  = sck_s & ~sck_q & ~csn_s;
   assign sck_fall  = ~sck_s & sck_q & ~csn_s;
   assign frame_end = csn_s & ~csn_q;

   logic [2:0] bit_cnt;
   logic [6:0] sh;
   logic [7:0] byte_in;
   assign byte_in = {sh, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt     <= '0;
         frame_bytes <= '0;
         sh          <= '0;
         frame_op    <= '0;
         frame_addr  <= '0;
      end else if (csn_s) begin
         bit_cnt     <= '0;
         frame_bytes <= '0;
      end else if (sck_rise) begin
         sh      <= byte_in[6:0];
         bit_cnt <= bit_cnt + 3'd1;
         if (bit_cnt == 3'd7) begin
            if (frame_bytes == 3'd0) begin
               frame_op <= byte_in;
            end else if (frame_bytes < FRAME_FULL) begin
               frame_addr <= ADDR_W'({frame_addr, byte_in});
            end
            if (frame_bytes != FRAME_FULL) frame_bytes <= frame_bytes + 3'd1;
         end
      end
   end

   assign frame_aligned = (bit_cnt == 3'd0);

   // status byte is (re)loaded on the falling edge that opens each byte slot
   logic       status_mode;
   logic [7:0] tx;
   assign status_mode = (frame_bytes != 3'd0) && (frame_op == OP_RDSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx <= '0;
      end else if (csn_s) begin
         tx <= '0;
      end else if (sck_fall) begin
         if (status_mode && bit_cnt == 3'd0) tx <= status_byte;
         else                                tx <= {tx[6:0], 1'b0};
      end
   end
   assign miso = tx[7];

   // R4: counters are clear whenever the previous cycle saw chip select high
   a_r4_idle_counts_clear : assert property (@(posedge clk) disable iff (!rst_n)
      csn_q |-> (bit_cnt == 3'd0 && frame_bytes == 3'd0));

   // R8: miso only moves on a falling edge or at frame release
   a_r8_miso_moves_on_fall : assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sck_fall) && !$past(csn_s)) |-> $stable(miso));

endmodule

// File: rtl/sfe_cmd_judge.sv
module sfe_cmd_judge
   import sfe_pkg::*;
#(
   parameter int SECTORS = 4,
   parameter int ADDR_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic              frame_aligned,
   input  logic [2:0]        frame_bytes,
   input  logic [7:0]        frame_op,
   input  logic [ADDR_W-1:0] frame_addr,
   input  logic [SECTORS-1:0] sect_lock,
   input  logic              busy,
   output logic              wel,
   output logic              start,
   output scope_e            start_scope,
   output logic [ADDR_W-1:0] start_base
);

   localparam int SECT_W = $clog2(SECTORS);

   if (SECTORS < 2 || (1 << SECT_W) != SECTORS) begin : g_bad_sect
      $error("sfe_cmd_judge: SECTORS must be a power of two, at least 2");
   end
   if (ADDR_W - SECT_W < LOW_64K) begin : g_bad_split
      $error("sfe_cmd_judge: a sector must hold at least one 64K block");
   end

   localparam logic [ADDR_W-1:0] MASK_4K  = {ADDR_W{1'b1}} << LOW_4K;
   localparam logic [ADDR_W-1:0] MASK_32K = {ADDR_W{1'b1}} << LOW_32K;
   localparam logic [ADDR_W-1:0] MASK_64K = {ADDR_W{1'b1}} << LOW_64K;

   logic [SECT_W-1:0]  sect_idx;
   logic [SECTORS-1:0] sect_hit;
   assign sect_idx = frame_addr[ADDR_W-1 -: SECT_W];

   for (genvar s = 0; s < SECTORS; s++) begin : g_hit
      assign sect_hit[s] = sect_lock[s] && (sect_idx == SECT_W'(s));
   end

   logic hit_locked, any_locked;
   assign hit_locked = |sect_hit;
   assign any_locked = |sect_lock;

   logic              is_blk, is_chip;
   scope_e            blk_scope;
   logic [ADDR_W-1:0] blk_mask;

   always_comb begin
      is_blk    = 1'b1;
      blk_scope = SC_4K;
      blk_mask  = MASK_4K;
      case (frame_op)
         OP_E4K:  ;
         OP_E32K: begin blk_scope = SC_32K; blk_mask = MASK_32K; end
         OP_E64K: begin blk_scope = SC_64K; blk_mask = MASK_64K; end
         default: is_blk = 1'b0;
      endcase
   end
   assign is_chip = (frame_op == OP_CHIPA) || (frame_op == OP_CHIPB);

   logic blk_ok, chip_ok, judge;
   assign blk_ok  = frame_aligned && (frame_bytes == FRAME_FULL) && wel && !hit_locked;
   assign chip_ok = frame_aligned && wel && !any_locked;
   assign judge   = frame_end && !busy && (frame_bytes != 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel         <= 1'b0;
         start       <= 1'b0;
         start_scope <= SC_4K;
         start_base  <= '0;
      end else begin
         start <= 1'b0;
         if (judge) begin
            if (frame_op == OP_WREN) begin
               if (frame_aligned) wel <= 1'b1;
            end else if (is_blk) begin
               wel <= 1'b0;
               if (blk_ok) begin
                  start       <= 1'b1;
                  start_scope <= blk_scope;
                  start_base  <= frame_addr & blk_mask;
               end
            end else if (is_chip) begin
               wel <= 1'b0;
               if (chip_ok) begin
                  start       <= 1'b1;
                  start_scope <= SC_CHIP;
                  start_base  <= '0;
               end
            end
         end
      end
   end

   a_r3_start_needs_wel : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(wel));

   a_r3_start_on_release : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(frame_end));

   a_r5_block_sector_open : assert property (@(posedge clk) disable iff (!rst_n)
      (start && start_scope != SC_CHIP) |-> !$past(hit_locked));

   a_r6_chip_all_open : assert property (@(posedge clk) disable iff (!rst_n)
      (start && start_scope == SC_CHIP) |-> ($past(sect_lock) == '0));

   a_r9_no_start_while_busy : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   a_r9_wel_frozen_busy : assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(wel));

endmodule

// File: rtl/sfe_erase_timer.sv
module sfe_erase_timer
   import sfe_pkg::*;
#(
   parameter int T_4K   = 4000,
   parameter int T_32K  = 20000,
   parameter int T_64K  = 36000,
   parameter int T_CHIP = 120000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  scope_e scope,
   input  logic   fail_inject,
   output logic   busy,
   output logic   err
);

   if (T_4K < 1 || T_32K < 1 || T_64K < 1 || T_CHIP < 1) begin : g_bad_dur
      $error("sfe_erase_timer: every duration must be at least one cycle");
   end

   localparam int T_MAX_A = (T_4K > T_32K) ? T_4K : T_32K;
   localparam int T_MAX_B = (T_64K > T_CHIP) ? T_64K : T_CHIP;
   localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
   localparam int CNT_W   = $clog2(T_MAX + 1);

   logic [CNT_W-1:0] load_val, cnt;
   logic             inj_seen;

   always_comb begin
      unique case (scope)
         SC_4K:   load_val = CNT_W'(T_4K - 1);
         SC_32K:  load_val = CNT_W'(T_32K - 1);
         SC_64K:  load_val = CNT_W'(T_64K - 1);
         default: load_val = CNT_W'(T_CHIP - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         err      <= 1'b0;
         inj_seen <= 1'b0;
      end else if (start && !busy) begin
         busy     <= 1'b1;
         cnt      <= load_val;
         err      <= 1'b0;
         inj_seen <= fail_inject;
      end else if (busy) begin
         if (cnt == '0) begin
            busy <= 1'b0;
            err  <= inj_seen | fail_inject;
         end else begin
            cnt      <= cnt - 1'b1;
            inj_seen <= inj_seen | fail_inject;
         end
      end
   end

   a_r7_busy_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);

   a_r7_start_raises_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r10_err_moves_with_busy : assert property (@(posedge clk) disable iff (!rst_n)
      $stable(busy) |-> $stable(err));

endmodule

// File: rtl/sfe_erase_ctrl.sv
module sfe_erase_ctrl
   import sfe_pkg::*;
#(
   parameter int SECTORS     = 4,
   parameter int ADDR_W      = 18,
   parameter int SYNC_STAGES = 2,
   parameter int T_4K        = 4000,
   parameter int T_32K       = 20000,
   parameter int T_64K       = 36000,
   parameter int T_CHIP      = 120000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sck,
   input  logic               spi_csn,
   input  logic               spi_mosi,
   output logic               spi_miso,
   input  logic [SECTORS-1:0] sector_lock,
   input  logic               fail_inject,
   output logic               erase_busy,
   output logic [1:0]         erase_scope,
   output logic [ADDR_W-1:0]  erase_base
);

   logic              f_end, f_aligned, wel, start, err;
   logic [2:0]        f_bytes;
   logic [7:0]        f_op, status_byte;
   logic [ADDR_W-1:0] f_addr;
   scope_e            st_scope;

   always_comb begin
      status_byte          = '0;
      status_byte[ST_BUSY] = erase_busy;
      status_byte[ST_WEL]  = wel;
      status_byte[ST_ERR]  = err;
   end

   sfe_spi_front #(
      .SYNC_STAGES (SYNC_STAGES),
      .ADDR_W      (ADDR_W)
   ) u_front (
      .clk           (clk),
      .rst_n         (rst_n),
      .sck           (spi_sck),
      .csn           (spi_csn),
      .mosi          (spi_mosi),
      .status_byte   (status_byte),
      .miso          (spi_miso),
      .frame_end     (f_end),
      .frame_aligned (f_aligned),
      .frame_bytes   (f_bytes),
      .frame_op      (f_op),
      .frame_addr    (f_addr)
   );

   sfe_cmd_judge #(
      .SECTORS (SECTORS),
      .ADDR_W  (ADDR_W)
   ) u_judge (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_end     (f_end),
      .frame_aligned (f_aligned),
      .frame_bytes   (f_bytes),
      .frame_op      (f_op),
      .frame_addr    (f_addr),
      .sect_lock     (sector_lock),
      .busy          (erase_busy),
      .wel           (wel),
      .start         (start),
      .start_scope   (st_scope),
      .start_base    (erase_base)
   );

   sfe_erase_timer #(
      .T_4K   (T_4K),
      .T_32K  (T_32K),
      .T_64K  (T_64K),
      .T_CHIP (T_CHIP)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .scope       (st_scope),
      .fail_inject (fail_inject),
      .busy        (erase_busy),
      .err         (err)
   );

   assign erase_scope = st_scope;

   // R7: the latch never reads set while the array is busy
   a_r7_busy_hides_wel : assert property (@(posedge clk) disable iff (!rst_n)
      erase_busy |-> !wel);

   // R9: the reported region only changes when a new erase is accepted
   a_r9_region_stable_busy : assert property (@(posedge clk) disable iff (!rst_n)
      $past(erase_busy) |-> ($stable(erase_base) && $stable(erase_scope)));

endmodule

// File: tb/tb_sfe_erase_ctrl.sv
module tb_sfe_erase_ctrl;
   import sfe_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int D4K = 40, D32K = 60, D64K = 1500, DCHIP = 1800;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0, fail_inject = 1'b0;
   logic [3:0] sector_lock = '0;
   logic spi_miso, erase_busy;
   logic [1:0] erase_scope;
   logic [17:0] erase_base;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfe_erase_ctrl #(
      .T_4K(D4K), .T_32K(D32K), .T_64K(D64K), .T_CHIP(DCHIP)
   ) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sector_lock(sector_lock),
      .fail_inject(fail_inject), .erase_busy(erase_busy),
      .erase_scope(erase_scope), .erase_base(erase_base)
   );

   int tests = 0, fails = 0;
   int busy_total = 0;
   logic cpol = 1'b0;
   logic done = 1'b0;

   always @(negedge clk) if (erase_busy) busy_total <= busy_total + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [39:0] d, input int nbits, output logic [15:0] rd);
      rd = '0;
      spi_sck = cpol;
      @(negedge clk);
      spi_csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_sck  = 1'b0;
         spi_mosi = (i < 40) ? d[39-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         rd = {rd[14:0], spi_miso};
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      if (!cpol) spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_csn = 1'b1;
      repeat (3*HALF) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] op, input logic [23:0] adr, input int nbits);
      logic [15:0] rd;
      xfer({op, adr, 8'h00}, nbits, rd);
   endtask

   task automatic read_status(input int nbytes, output logic [15:0] rd);
      xfer({OP_RDSR, 32'h0}, 8 + 8*nbytes, rd);
   endtask

   task automatic wait_idle();
      int guard = 0;
      repeat (20) @(negedge clk);
      while (erase_busy && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   function automatic int dur_of(input logic [1:0] sc);
      case (sc)
         2'd0: return D4K;
         2'd1: return D32K;
         2'd2: return D64K;
         default: return DCHIP;
      endcase
   endfunction

   typedef struct packed {
      logic        wen;
      logic [7:0]  op;
      logic [23:0] adr;
      logic [7:0]  nbits;
      logic [3:0]  lock;
      logic        go;
      logic [1:0]  scope;
      logic [17:0] base;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h20, 24'h012345, 8'd32, 4'b0000, 1'b1, 2'd0, 18'h12000},
      '{1'b1, 8'h52, 24'h03ABCD, 8'd32, 4'b0000, 1'b1, 2'd1, 18'h38000},
      '{1'b1, 8'hD8, 24'h02FFFF, 8'd32, 4'b0000, 1'b1, 2'd2, 18'h20000},
      '{1'b0, 8'h20, 24'h001000, 8'd32, 4'b0000, 1'b0, 2'd0, 18'h0},
      '{1'b1, 8'h20, 24'h011000, 8'd28, 4'b0000, 1'b0, 2'd0, 18'h0},
      '{1'b1, 8'h52, 24'h010000, 8'd24, 4'b0000, 1'b0, 2'd0, 18'h0},
      '{1'b1, 8'hD8, 24'h025000, 8'd32, 4'b0100, 1'b0, 2'd0, 18'h0},
      '{1'b1, 8'h20, 24'h025ABC, 8'd32, 4'b1011, 1'b1, 2'd0, 18'h25000},
      '{1'b1, 8'h60, 24'h000000, 8'd8,  4'b0000, 1'b1, 2'd3, 18'h0},
      '{1'b1, 8'hC7, 24'hFFFFFF, 8'd24, 4'b0000, 1'b1, 2'd3, 18'h0},
      '{1'b1, 8'h60, 24'h000000, 8'd8,  4'b1000, 1'b0, 2'd0, 18'h0},
      '{1'b1, 8'hC7, 24'h000000, 8'd12, 4'b0000, 1'b0, 2'd0, 18'h0}
   };

   function automatic string vtag(input int i);
      case (i)
         3:       return "R3";
         4, 5:    return "R4";
         6, 7:    return "R5";
         8, 9:    return "R6";
         10:      return "R6";
         11:      return "R4";
         default: return "R2";
      endcase
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] st;
      int b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // reset state (R8 status byte all zero)
      check("R8 reset busy", erase_busy, 0);
      check("R8 reset miso", spi_miso, 0);
      check("R2 reset scope", erase_scope, 0);
      check("R2 reset base", erase_base, 0);
      read_status(1, st);
      check("R8 reset status", st[7:0], 8'h00);

      // R1: latch set and read back in each clock polarity
      for (int m = 0; m < 2; m++) begin
         cpol = m[0];
         send(OP_WREN, 24'h0, 8);
         read_status(1, st);
         check(m == 0 ? "R1 mode0 wren" : "R1 mode3 wren", st[7:0], 8'h02);
      end

      // table walk: modes alternate with the index
      for (int i = 0; i < NV; i++) begin
         cpol = i[0];
         sector_lock = VEC[i].lock;
         if (VEC[i].wen) send(OP_WREN, 24'h0, 8);
         else begin
            // make sure the latch is clear: a refused erase clears it
            sector_lock = 4'hF;
            send(OP_E4K, 24'h0, 32);
            sector_lock = VEC[i].lock;
         end
         b0 = busy_total;
         send(VEC[i].op, VEC[i].adr, int'(VEC[i].nbits));
         wait_idle();
         if (VEC[i].go) begin
            check($sformatf("R7 duration vec %0d", i), busy_total - b0, dur_of(VEC[i].scope));
            check($sformatf("%s scope vec %0d", vtag(i), i), erase_scope, VEC[i].scope);
            check($sformatf("%s base vec %0d", vtag(i), i), erase_base, VEC[i].base);
         end else begin
            check($sformatf("%s no erase vec %0d", vtag(i), i), busy_total - b0, 0);
         end
         read_status(1, st);
         check($sformatf("%s latch cleared vec %0d", vtag(i), i), st[7:0], 8'h00);
      end
      sector_lock = '0;

      // R8 and R9: status and ignored commands during a long erase
      cpol = 1'b0;
      send(OP_WREN, 24'h0, 8);
      b0 = busy_total;
      send(OP_E64K, 24'h01F00F, 32);
      read_status(2, st);
      check("R8 busy status byte 1", st[15:8], 8'h01);
      check("R8 busy status byte 2", st[7:0], 8'h01);
      send(OP_WREN, 24'h0, 8);
      send(OP_CHIPB, 24'h0, 8);
      check("R9 still busy", erase_busy, 1);
      wait_idle();
      check("R9 single erase length", busy_total - b0, D64K);
      check("R9 scope kept", erase_scope, 2);
      check("R9 base kept", erase_base, 18'h10000);
      read_status(1, st);
      check("R9 wren ignored", st[7:0], 8'h00);

      // R10: injected failure, persistence, clear on next erase
      cpol = 1'b1;
      send(OP_WREN, 24'h0, 8);
      send(OP_E64K, 24'h030000, 32);
      @(negedge clk); fail_inject = 1'b1;
      @(negedge clk); fail_inject = 1'b0;
      wait_idle();
      read_status(1, st);
      check("R10 error set", st[7:0], 8'h20);
      send(OP_WREN, 24'h0, 8);
      read_status(1, st);
      check("R10 error kept with latch", st[7:0], 8'h22);
      send(OP_CHIPA, 24'h0, 8);
      read_status(1, st);
      check("R10 error cleared at start", st[7:0], 8'h01);
      wait_idle();
      read_status(1, st);
      check("R10 clean finish", st[7:0], 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule